// File: doc/BRIEF.md
# Bitstream Header Ratio Selector

This block sits in the path of a 32-bit configuration stream and lets every word through untouched, with the downstream ready passed straight back upstream. While the words go by, it counts them from the start of the stream and looks at two fixed positions in the header. One word carries a two-bit field that shows whether the payload is encrypted. A later word carries a bit that shows whether the payload is compressed.

Once the later of those two words has been accepted, the block issues a clock-to-data ratio code and a width select for the configuration port downstream. A width input picks 16-bit or 32-bit mode. If the stream ends before the header window is complete, the block raises a sticky length error and issues no ratio. A start pulse re-arms the block for the next stream.

Top module: `hdr_ratio_sel`

## Requirements
- R1: Output valid, data and last equal the input valid, data and last in every cycle, and in_ready equals out_ready. A word is accepted when in_valid and out_ready are both high.
- R2: Word index 0 is the first word accepted after a start pulse or after reset. Only accepted words advance the index, so a stalled word is counted once.
- R3: The stream is encrypted when bits [3:2] of word 69 are not both zero.
- R4: The stream is compressed when bit 1 of word 229 is 0.
- R5: With neither encryption nor compression, ratio_code is 0 (x1) in both widths.
- R6: In 16-bit mode (width32_i = 0), ratio_code is 2 (x4) for a compressed stream, with or without encryption. It is 1 (x2) for an encrypted stream that is not compressed.
- R7: In 32-bit mode (width32_i = 1), ratio_code is 3 (x8) for a compressed stream and 2 (x4) for an encrypted stream that is not compressed. The ratio codes are 0 = x1, 1 = x2, 2 = x4 and 3 = x8.
- R8: ratio_valid is high for exactly one cycle, the cycle after word 229 is accepted. In that same cycle, width_sel takes the value width32_i had when word 229 was accepted. ratio_code and width_sel then hold until the next start pulse.
- R9: If a word carrying in_last is accepted at an index below 229, len_err goes high in the next cycle and stays high until a start pulse, and no ratio_valid is issued. A stream whose last word is word 229 is valid.
- R10: Once the ratio has been issued or the length error raised, further words change no output except the pass-through until the next start pulse. A start pulse clears len_err, ratio_code and width_sel to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Re-arm pulse for a new stream |
| width32_i | input | 1 | 1 = 32-bit mode, 0 = 16-bit mode |
| in_valid | input | 1 | Upstream word valid |
| in_data | input | 32 | Upstream word |
| in_last | input | 1 | Marks the final word of the stream |
| in_ready | output | 1 | Ready to upstream (equal to out_ready) |
| out_valid | output | 1 | Downstream word valid |
| out_data | output | 32 | Downstream word |
| out_last | output | 1 | Downstream final-word marker |
| out_ready | input | 1 | Downstream ready |
| ratio_valid | output | 1 | One-cycle pulse when the ratio is known |
| ratio_code | output | 2 | Ratio code, 0 = x1, 1 = x2, 2 = x4, 3 = x8 |
| width_sel | output | 1 | Width captured with the ratio |
| len_err | output | 1 | Sticky error: stream ended inside the header |

## Verification
The bench covers all eight combinations of width, encryption and compression, including both nonzero encodings of the encryption field. A design that ignored one bit of that field, inverted the compression bit or missed the doubling in 32-bit mode would issue the wrong code. Streams are run with downstream stalls: a counter that advanced on valid alone would land on the wrong words and report a pulse at the wrong count. The length boundary is tested from both sides: a last word at index 228 must raise the error and a last word at index 229 must not, so an off-by-one compare fails one of the two. After the header or an error, trailing words are sent to catch a design that keeps counting or raises a second pulse.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;

   typedef enum logic [1:0] {
      RATIO_X1 = 2'd0,
      RATIO_X2 = 2'd1,
      RATIO_X4 = 2'd2,
      RATIO_X8 = 2'd3
   } ratio_e;

endpackage

// File: rtl/hdr_word_counter.sv
module hdr_word_counter #(
   parameter int CNT_W   = 8,
   parameter int SAT_VAL = 230
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             step_i,
   output logic [CNT_W-1:0] idx_o
);

   localparam logic [CNT_W-1:0] SAT = CNT_W'(SAT_VAL);

   if (SAT_VAL >= (1 << CNT_W)) begin : g_bad_width
      $error("hdr_word_counter: CNT_W too small for SAT_VAL");
   end

   logic [CNT_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (clear_i) begin
         idx_q <= '0;
      end else if (step_i && idx_q != SAT) begin
         idx_q <= idx_q + CNT_W'(1);
      end
   end

   assign idx_o = idx_q;

   // R2: every counted word moves the index forward by exactly one
   a_r2_step_once: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !clear_i && idx_q != SAT) |=> (idx_q == $past(idx_q) + CNT_W'(1)));

   // R2: with no step and no clear the index holds
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !clear_i) |=> $stable(idx_q));

endmodule

// File: rtl/hdr_flag_capture.sv
module hdr_flag_capture #(
   parameter int CNT_W   = 8,
   parameter int AT_IDX  = 69,
   parameter int FIELD_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_i,
   input  logic               step_i,
   input  logic [CNT_W-1:0]   idx_i,
   input  logic [FIELD_W-1:0] field_i,
   output logic               flag_o
);

   localparam logic [CNT_W-1:0] AT = CNT_W'(AT_IDX);

   if (FIELD_W < 1) begin : g_bad_field
      $error("hdr_flag_capture: FIELD_W must be at least 1");
   end

   logic hit;
   logic field_set;
   logic flag_q;

   assign hit = step_i && (idx_i == AT);

   if (FIELD_W == 1) begin : g_single
      assign field_set = field_i[0];
   end else begin : g_multi
      assign field_set = |field_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (clear_i) begin
         flag_q <= 1'b0;
      end else if (hit) begin
         flag_q <= field_set;
      end
   end

   assign flag_o = flag_q;

   // R3: the flag only moves on the capture word or a clear
   a_r3_flag_only_at_word: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !clear_i) |=> $stable(flag_q));

   // R3: an all-zero field leaves the flag clear
   a_r3_zero_field: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !clear_i && field_i == '0) |=> !flag_q);

endmodule

// File: rtl/hdr_ratio_calc.sv
module hdr_ratio_calc
   import hdr_ratio_pkg::*;
(
   input  logic   enc_i,
   input  logic   cmp_i,
   input  logic   wide_i,
   output ratio_e code_o
);

   ratio_e base;

   always_comb begin
      if (cmp_i) begin
         base = RATIO_X4;
      end else if (enc_i) begin
         base = RATIO_X2;
      end else begin
         base = RATIO_X1;
      end
      if (wide_i && base != RATIO_X1) begin
         code_o = ratio_e'(base + 2'd1);
      end else begin
         code_o = base;
      end
   end

   // R5: a plain stream is x1 in both widths
   always_comb begin
      a_r5_plain_x1: assert (!((!enc_i && !cmp_i) && code_o != RATIO_X1));
   end

endmodule

// File: rtl/hdr_ratio_sel.sv
module hdr_ratio_sel
   import hdr_ratio_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ENC_IDX = 69,
   parameter int ENC_LSB = 2,
   parameter int ENC_MSB = 3,
   parameter int CMP_IDX = 229,
   parameter int CMP_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              width32_i,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   output logic              in_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last,
   input  logic              out_ready,
   output logic              ratio_valid,
   output logic [1:0]        ratio_code,
   output logic              width_sel,
   output logic              len_err
);

   localparam int CNT_W   = $clog2(CMP_IDX + 2);
   localparam int FIELD_W = ENC_MSB - ENC_LSB + 1;
   localparam logic [CNT_W-1:0] CMP_AT = CNT_W'(CMP_IDX);

   if (ENC_IDX >= CMP_IDX) begin : g_bad_order
      $error("hdr_ratio_sel: encryption word must precede compression word");
   end
   if (ENC_MSB < ENC_LSB || ENC_MSB >= DATA_W || CMP_BIT >= DATA_W) begin : g_bad_bits
      $error("hdr_ratio_sel: flag bit positions out of range");
   end

   // pass-through
   assign out_valid = in_valid;
   assign out_data  = in_data;
   assign out_last  = in_last;
   assign in_ready  = out_ready;

   logic             accept;
   logic             armed_q;
   logic             step;
   logic             at_cmp;
   logic             short_end;
   logic [CNT_W-1:0] idx;
   logic             enc_flag;
   ratio_e           code_next;

   logic             ratio_valid_q;
   ratio_e           ratio_code_q;
   logic             width_sel_q;
   logic             len_err_q;

   assign accept    = in_valid && out_ready;
   assign step      = accept && armed_q && !start_i;
   assign at_cmp    = step && (idx == CMP_AT);
   assign short_end = step && in_last && (idx < CMP_AT);

   hdr_word_counter #(
      .CNT_W   (CNT_W),
      .SAT_VAL (CMP_IDX + 1)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (start_i),
      .step_i  (step),
      .idx_o   (idx)
   );

   hdr_flag_capture #(
      .CNT_W   (CNT_W),
      .AT_IDX  (ENC_IDX),
      .FIELD_W (FIELD_W)
   ) u_enc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (start_i),
      .step_i  (step),
      .idx_i   (idx),
      .field_i (in_data[ENC_MSB:ENC_LSB]),
      .flag_o  (enc_flag)
   );

   hdr_ratio_calc u_calc (
      .enc_i  (enc_flag),
      .cmp_i  (!in_data[CMP_BIT]),
      .wide_i (width32_i),
      .code_o (code_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q       <= 1'b1;
         ratio_valid_q <= 1'b0;
         ratio_code_q  <= RATIO_X1;
         width_sel_q   <= 1'b0;
         len_err_q     <= 1'b0;
      end else if (start_i) begin
         armed_q       <= 1'b1;
         ratio_valid_q <= 1'b0;
         ratio_code_q  <= RATIO_X1;
         width_sel_q   <= 1'b0;
         len_err_q     <= 1'b0;
      end else begin
         ratio_valid_q <= at_cmp;
         if (at_cmp) begin
            armed_q      <= 1'b0;
            ratio_code_q <= code_next;
            width_sel_q  <= width32_i;
         end else if (short_end) begin
            armed_q   <= 1'b0;
            len_err_q <= 1'b1;
         end
      end
   end

   assign ratio_valid = ratio_valid_q;
   assign ratio_code  = ratio_code_q;
   assign width_sel   = width_sel_q;
   assign len_err     = len_err_q;

   // R8: the ratio pulse lasts a single cycle
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_valid_q |=> !ratio_valid_q);

   // R8: the code holds unless the compression word lands or a start arrives
   a_r8_code_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !at_cmp) |=> $stable(ratio_code_q) && $stable(width_sel_q));

   // R9: the error only rises after a last word was accepted
   a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(len_err_q) |-> $past(in_last && accept));

   // R9: an error and a ratio never coexist in one stream
   a_r9_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      len_err_q |-> !ratio_valid_q);

   // R6: 16-bit mode never reaches x8
   a_r6_narrow_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_valid_q && !width_sel_q) |-> ratio_code_q != RATIO_X8);

   // R10: a disarmed block does not pulse again
   a_r10_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !start_i) |=> !ratio_valid_q);

endmodule

// File: tb/hdr_ratio_sel_tb.sv
module hdr_ratio_sel_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        width32_i = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_last = 1'b0;
   logic        in_ready;
   logic        out_valid;
   logic [31:0] out_data;
   logic        out_last;
   logic        out_ready = 1'b1;
   logic        ratio_valid;
   logic [1:0]  ratio_code;
   logic        width_sel;
   logic        len_err;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit finished = 0;

   logic [32:0] exp_q[$];
   int          pulses = 0;
   int          accepted = 0;
   int          acc_at_pulse = -1;
   logic [1:0]  seen_code = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   hdr_ratio_sel u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .width32_i   (width32_i),
      .in_valid    (in_valid),
      .in_data     (in_data),
      .in_last     (in_last),
      .in_ready    (in_ready),
      .out_valid   (out_valid),
      .out_data    (out_data),
      .out_last    (out_last),
      .out_ready   (out_ready),
      .ratio_valid (ratio_valid),
      .ratio_code  (ratio_code),
      .width_sel   (width_sel),
      .len_err     (len_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // monitor: pass-through scoreboard and ratio pulse tracking
   always @(negedge clk) begin
      if (rst_n) begin
         if (ratio_valid) begin
            pulses++;
            seen_code = ratio_code;
            acc_at_pulse = accepted;
         end
         if (out_valid && out_ready) begin
            accepted++;
            if (exp_q.size() == 0) begin
               chk(0, "R1 unexpected word", int'(out_data), 0);
            end else begin
               logic [32:0] e;
               e = exp_q.pop_front();
               chk({out_last, out_data} == e, "R1 data/last", int'(out_data), int'(e[31:0]));
            end
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         chk(0, "watchdog", cycles, WATCHDOG);
         finish_run();
      end
   end

   task automatic do_start();
      @(posedge clk); #1;
      start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
      pulses = 0;
      accepted = 0;
      acc_at_pulse = -1;
   endtask

   function automatic logic [31:0] word_of(input int i, input logic [1:0] encb, input logic cmpb);
      logic [31:0] d;
      d = 32'hA5C30F00 ^ (i * 32'h01030507);
      if (i == 69)  d = (d & ~32'h0000000C) | {28'd0, encb, 2'b00};
      if (i == 229) d = (d & ~32'h00000002) | {30'd0, cmpb, 1'b0};
      return d;
   endfunction

   // driver: pushes expected words, stalls downstream on a pattern
   task automatic send_words(input int n, input logic [1:0] encb, input logic cmpb,
                             input logic w32, input bit stall);
      width32_i = w32;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         in_valid = 1'b1;
         in_data  = word_of(i, encb, cmpb);
         in_last  = (i == n - 1);
         exp_q.push_back({in_last, in_data});
         if (stall && (i % 5 == 2)) begin
            out_ready = 1'b0;
            @(negedge clk);
            chk(in_ready == 1'b0 && out_valid == 1'b1, "R1 ready mirror", int'(in_ready), 0);
            @(posedge clk); #1;
            out_ready = 1'b1;
         end
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_last  = 1'b0;
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic run_ok(input string tag, input int n, input logic [1:0] encb,
                         input logic cmpb, input logic w32, input bit stall,
                         input logic [1:0] exp_code);
      do_start();
      send_words(n, encb, cmpb, w32, stall);
      chk(pulses == 1, {tag, " R8 one pulse"}, pulses, 1);
      chk(acc_at_pulse == 230, {tag, " R2 pulse after word 229"}, acc_at_pulse, 230);
      chk(seen_code == exp_code, {tag, " code at pulse"}, int'(seen_code), int'(exp_code));
      chk(ratio_code == exp_code, {tag, " R8 code held"}, int'(ratio_code), int'(exp_code));
      chk(width_sel == w32, {tag, " R8 width"}, int'(width_sel), int'(w32));
      chk(len_err == 1'b0, {tag, " R9 no error"}, int'(len_err), 0);
      chk(exp_q.size() == 0, {tag, " R1 all words out"}, exp_q.size(), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(ratio_valid == 0 && ratio_code == 0 && width_sel == 0 && len_err == 0,
          "reset state", int'({ratio_valid, ratio_code, width_sel, len_err}), 0);
      rst_n = 1'b1;

      // R5: plain stream, both widths
      run_ok("R5 w16 plain", 230, 2'b00, 1'b1, 1'b0, 0, 2'd0);
      run_ok("R5 w32 plain", 240, 2'b00, 1'b1, 1'b1, 1, 2'd0);
      // R6: 16-bit encrypted / compressed / both; R3 each field bit; R4 inverted bit
      run_ok("R6 R3 w16 enc lo", 230, 2'b01, 1'b1, 1'b0, 1, 2'd1);
      run_ok("R6 R4 w16 cmp", 235, 2'b00, 1'b0, 1'b0, 0, 2'd2);
      run_ok("R6 w16 both", 230, 2'b11, 1'b0, 1'b0, 1, 2'd2);
      // R7: 32-bit doubling
      run_ok("R7 R3 w32 enc hi", 230, 2'b10, 1'b1, 1'b1, 1, 2'd2);
      run_ok("R7 R4 w32 cmp", 230, 2'b00, 1'b0, 1'b1, 0, 2'd3);
      run_ok("R7 w32 both", 260, 2'b01, 1'b0, 1'b1, 1, 2'd3);

      // R10: trailing words after the header change nothing
      send_words(120, 2'b00, 1'b1, 1'b0, 0);
      chk(pulses == 1 && ratio_code == 2'd3 && width_sel == 1'b1,
          "R10 trailing words ignored", int'(ratio_code), 3);

      // R9: last word at index 228 is short
      do_start();
      chk(ratio_code == 0 && width_sel == 0, "R10 start clears code", int'(ratio_code), 0);
      send_words(229, 2'b11, 1'b0, 1'b1, 1);
      chk(len_err == 1'b1, "R9 short by one", int'(len_err), 1);
      chk(pulses == 0, "R9 no pulse on short", pulses, 0);

      // R10: words after an error do not produce a ratio
      send_words(240, 2'b11, 1'b0, 1'b1, 0);
      chk(pulses == 0 && len_err == 1'b1, "R10 quiet after error", pulses, 0);

      // R9: very short stream, then start clears the error
      do_start();
      chk(len_err == 1'b0, "R10 start clears error", int'(len_err), 0);
      send_words(100, 2'b00, 1'b0, 1'b0, 0);
      chk(len_err == 1'b1 && pulses == 0, "R9 short stream", int'(len_err), 1);

      // R2: fresh stream after an error counts from zero
      run_ok("R2 restart", 230, 2'b10, 1'b1, 1'b0, 1, 2'd1);

      finish_run();
   end

endmodule